// File: doc/BRIEF.md
# Accumulator Machine Instruction Sequencer

This block is the multi-cycle control and datapath core of a small single-accumulator processor. It fetches each instruction through an explicit chain of register transfers: program counter to address register, a read strobe, the returned word into the data register, and then the data register into the instruction register. After the fetch it decodes the instruction. It reads a memory operand through the same address and data registers when the instruction needs one, then executes and writes back. It moves one register transfer per clock.

The block drives a simple synchronous memory port. A read strobe presented on one clock edge returns its word on the following cycle. A write strobe stores the data word at the presented address on that edge. Arithmetic keeps four condition flags (negative, zero, signed overflow, carry), and the two conditional branches test them later. The core runs until it executes a halt instruction. It then stays frozen until reset.

Top module: `acc_seq`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the accumulator and the flags, and drops `halted`. The first read strobe after reset comes one cycle after reset is released and addresses word 0.
- R2: An instruction fetch takes four cycles: program counter to address register, read strobe, returned word captured in the data register one cycle after the strobe, and data register to instruction register together with a program counter increment of one.
- R3: An instruction word holds the opcode in bits [15:12] and an address field in bits [11:0]. The opcodes are 1 load, 2 store, 3 add, 4 subtract, 5 jump, 6 branch-if-zero, 7 branch-if-negative and 15 halt. Any other opcode has no effect besides advancing to the next instruction.
- R4: Load, add and subtract read their operand at the address field and take 8 cycles in total. Store takes 7 cycles. Jump, both branches, halt and undefined opcodes take 5 cycles.
- R5: Store writes the accumulator to the address field with a single cycle of write strobe. No other instruction strobes a write.
- R6: Add sets N to the result's top bit, Z when the result is zero, V on signed overflow and C on carry out of the top bit. `cond_flags` carries N, Z, V and C in bits 3, 2, 1 and 0.
- R7: Subtract computes accumulator minus operand. It sets C to 1 when no borrow occurs, V on signed overflow, and N and Z as for add.
- R8: Load updates N and Z from the loaded word and keeps V and C. Flags change only when a load, add or subtract executes.
- R9: Jump always loads the program counter from the address field. Branch-if-zero and branch-if-negative do so only when Z or N respectively is set, and otherwise continue at the next word.
- R10: After a halt instruction `halted` is asserted and stays asserted, no read or write strobe is issued, and all registers hold until reset.
- R11: The read and write strobes are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory word address, driven from the address register |
| mem_rd | output | 1 | Read strobe; data returns the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data, driven from the data register |
| mem_rdata | input | 16 | Read data from memory |
| halted | output | 1 | High once a halt instruction has executed |
| cond_flags | output | 4 | Flags {N, Z, V, C} |

## Verification
The assertions check on every cycle the things that hold at all times. The strobes are never asserted together. The halted state never clears on its own and stays silent on the bus. Every fetch moves the program counter by one. The flags move only in the execute step. Stored data always equals the accumulator, and reset clears the architectural state. The arithmetic values, the flag values at boundaries such as signed overflow and a wrapping sum, the branch decisions taken and not taken, the inertness of an undefined opcode and the per-instruction cycle counts can only be shown by the bench's programs. The bench checks them through the write traffic they produce and through the flag output.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    localparam int WORD_W = 16;
    localparam int OPC_W  = 4;
    localparam int ADDR_W = WORD_W - OPC_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [OPC_W-1:0]  opc_t;

    localparam opc_t OPC_LOAD  = 4'd1;
    localparam opc_t OPC_STORE = 4'd2;
    localparam opc_t OPC_ADD   = 4'd3;
    localparam opc_t OPC_SUB   = 4'd4;
    localparam opc_t OPC_JUMP  = 4'd5;
    localparam opc_t OPC_BRZ   = 4'd6;
    localparam opc_t OPC_BRN   = 4'd7;
    localparam opc_t OPC_HALT  = 4'd15;

    typedef enum logic [3:0] {
        ST_FMAR, ST_FRD, ST_FMDR, ST_FIR, ST_DEC,
        ST_ORD, ST_OMDR, ST_EXE, ST_SMDR, ST_SWR, ST_HALT
    } st_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef struct packed {
        logic mar_pc;
        logic mar_ir;
        logic mdr_mem;
        logic mdr_acc;
        logic ir_ld;
        logic pc_inc;
        logic pc_jmp;
        logic exe;
        logic rd;
        logic wr;
    } ctl_t;

    typedef struct packed {
        word_t  res;
        flags_t fl;
    } alu_out_t;

    function automatic opc_t opc_of(input word_t w);
        return w[WORD_W-1 -: OPC_W];
    endfunction

    function automatic addr_t addr_of(input word_t w);
        return w[ADDR_W-1:0];
    endfunction

    function automatic alu_out_t alu_calc(input logic sub, input word_t a, input word_t b);
        alu_out_t      o;
        word_t         bb;
        logic [WORD_W:0] s;
        bb   = sub ? ~b : b;
        s    = {1'b0, a} + {1'b0, bb} + {{WORD_W{1'b0}}, sub};
        o.res  = s[WORD_W-1:0];
        o.fl.c = s[WORD_W];
        o.fl.n = s[WORD_W-1];
        o.fl.z = (s[WORD_W-1:0] == '0);
        o.fl.v = (a[WORD_W-1] == bb[WORD_W-1]) && (s[WORD_W-1] != a[WORD_W-1]);
        return o;
    endfunction

endpackage

// File: rtl/acc_seq_fsm.sv
module acc_seq_fsm
    import acc_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  opc_t   opc,
    input  flags_t flags,
    output st_e    st,
    output ctl_t   ctl
);

    st_e st_q;
    st_e st_nx;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_FMAR;
        else     st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        ctl   = '0;
        unique case (st_q)
            ST_FMAR: begin ctl.mar_pc  = 1'b1; st_nx = ST_FRD;  end
            ST_FRD:  begin ctl.rd      = 1'b1; st_nx = ST_FMDR; end
            ST_FMDR: begin ctl.mdr_mem = 1'b1; st_nx = ST_FIR;  end
            ST_FIR:  begin
                ctl.ir_ld  = 1'b1;
                ctl.pc_inc = 1'b1;
                st_nx      = ST_DEC;
            end
            ST_DEC: begin
                st_nx = ST_FMAR;
                case (opc)
                    OPC_LOAD, OPC_ADD, OPC_SUB: begin
                        ctl.mar_ir = 1'b1;
                        st_nx      = ST_ORD;
                    end
                    OPC_STORE: begin
                        ctl.mar_ir = 1'b1;
                        st_nx      = ST_SMDR;
                    end
                    OPC_JUMP: ctl.pc_jmp = 1'b1;
                    OPC_BRZ:  ctl.pc_jmp = flags.z;
                    OPC_BRN:  ctl.pc_jmp = flags.n;
                    OPC_HALT: st_nx = ST_HALT;
                    default:  st_nx = ST_FMAR;
                endcase
            end
            ST_ORD:  begin ctl.rd      = 1'b1; st_nx = ST_OMDR; end
            ST_OMDR: begin ctl.mdr_mem = 1'b1; st_nx = ST_EXE;  end
            ST_EXE:  begin ctl.exe     = 1'b1; st_nx = ST_FMAR; end
            ST_SMDR: begin ctl.mdr_acc = 1'b1; st_nx = ST_SWR;  end
            ST_SWR:  begin ctl.wr      = 1'b1; st_nx = ST_FMAR; end
            ST_HALT: st_nx = ST_HALT;
            default: st_nx = ST_FMAR;
        endcase
    end

    assign st = st_q;

endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
    import acc_seq_pkg::*;
(
    input  opc_t   opc,
    input  word_t  acc,
    input  word_t  opnd,
    input  flags_t fl_in,
    output word_t  acc_nx,
    output flags_t fl_nx
);

    alu_out_t sum;

    always_comb begin
        sum    = alu_calc(opc == OPC_SUB, acc, opnd);
        acc_nx = acc;
        fl_nx  = fl_in;
        case (opc)
            OPC_LOAD: begin
                acc_nx   = opnd;
                fl_nx.n  = opnd[WORD_W-1];
                fl_nx.z  = (opnd == '0);
            end
            OPC_ADD, OPC_SUB: begin
                acc_nx = sum.res;
                fl_nx  = sum.fl;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_seq_dp.sv
module acc_seq_dp
    import acc_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ctl_t   ctl,
    input  word_t  mem_rdata,
    output addr_t  pc_o,
    output addr_t  mar_o,
    output word_t  mdr_o,
    output word_t  ir_o,
    output word_t  acc_o,
    output flags_t flags_o
);

    addr_t  pc_q, mar_q;
    word_t  mdr_q, ir_q, acc_q;
    flags_t fl_q;
    word_t  acc_nx;
    flags_t fl_nx;

    acc_seq_alu u_alu (
        .opc    (opc_of(ir_q)),
        .acc    (acc_q),
        .opnd   (mdr_q),
        .fl_in  (fl_q),
        .acc_nx (acc_nx),
        .fl_nx  (fl_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            mar_q <= '0;
            mdr_q <= '0;
            ir_q  <= '0;
            acc_q <= '0;
            fl_q  <= '0;
        end else begin
            if (ctl.mar_pc)  mar_q <= pc_q;
            if (ctl.mar_ir)  mar_q <= addr_of(ir_q);
            if (ctl.mdr_mem) mdr_q <= mem_rdata;
            if (ctl.mdr_acc) mdr_q <= acc_q;
            if (ctl.ir_ld)   ir_q  <= mdr_q;
            if (ctl.pc_inc)  pc_q  <= pc_q + 1'b1;
            if (ctl.pc_jmp)  pc_q  <= addr_of(ir_q);
            if (ctl.exe) begin
                acc_q <= acc_nx;
                fl_q  <= fl_nx;
            end
        end
    end

    assign pc_o    = pc_q;
    assign mar_o   = mar_q;
    assign mdr_o   = mdr_q;
    assign ir_o    = ir_q;
    assign acc_o   = acc_q;
    assign flags_o = fl_q;

endmodule

// File: rtl/acc_seq.sv
module acc_seq
    import acc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              halted,
    output logic [3:0]        cond_flags
);

    st_e    st_q;
    ctl_t   ctl;
    addr_t  pc_q, mar_q;
    word_t  mdr_q, ir_q, acc_q;
    flags_t flags_q;

    acc_seq_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .opc   (opc_of(ir_q)),
        .flags (flags_q),
        .st    (st_q),
        .ctl   (ctl)
    );

    acc_seq_dp u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .pc_o      (pc_q),
        .mar_o     (mar_q),
        .mdr_o     (mdr_q),
        .ir_o      (ir_q),
        .acc_o     (acc_q),
        .flags_o   (flags_q)
    );

    assign mem_addr   = mar_q;
    assign mem_rd     = ctl.rd;
    assign mem_wr     = ctl.wr;
    assign mem_wdata  = mdr_q;
    assign halted     = (st_q == ST_HALT);
    assign cond_flags = flags_q;

endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk
    import acc_seq_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input st_e    st_q,
    input addr_t  pc_q,
    input word_t  acc_q,
    input flags_t flags_q,
    input logic   mem_rd,
    input logic   mem_wr,
    input word_t  mem_wdata,
    input logic   halted
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (pc_q == '0 && acc_q == '0 && flags_q == '0 && !halted)); // R1

    AST_FETCH_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_FIR) |=> (pc_q == addr_t'($past(pc_q) + 1'b1))); // R2

    AST_STORE_FROM_ACC: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_wdata == acc_q)); // R5

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_EXE) |=> $stable(flags_q)); // R8

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc_q) && $stable(acc_q))); // R10

    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_rd && !mem_wr)); // R10

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R11

endmodule

bind acc_seq acc_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .st_q      (st_q),
    .pc_q      (pc_q),
    .acc_q     (acc_q),
    .flags_q   (flags_q),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .halted    (halted)
);

// File: tb/acc_seq_bench.sv
`timescale 1ns/1ps
module acc_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        halted;
    logic [3:0]  cond_flags;

    always #2 clk = ~clk;

    acc_seq u_acc_seq (
        .clk        (clk),
        .rst        (rst),
        .mem_addr   (mem_addr),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .halted     (halted),
        .cond_flags (cond_flags)
    );

    // bench memory: 256 words, one-cycle read latency, preload port
    logic [15:0] mem [256];
    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;

    always @(posedge clk) begin
        if (ld_en)       mem[ld_addr] <= ld_data;
        else if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd)      mem_rdata <= mem[mem_addr[7:0]];
    end

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard
    typedef struct {
        logic [11:0] a;
        logic [15:0] d;
        logic [3:0]  f;
        string       req;
    } exp_t;
    exp_t sb_q[$];

    task automatic push_wr(input logic [11:0] a, input logic [15:0] d,
                           input logic [3:0] f, input string req);
        exp_t e;
        e.a = a; e.d = d; e.f = f; e.req = req;
        sb_q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (!rst && mem_wr) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R5", "unexpected write at addr", {20'd0, mem_addr}, 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(mem_addr == e.a, e.req, "write address", {20'd0, mem_addr}, {20'd0, e.a});
                check(mem_wdata == e.d, e.req, "write data", {16'd0, mem_wdata}, {16'd0, e.d});
                check(cond_flags == e.f, e.req, "flags at write", {28'd0, cond_flags}, {28'd0, e.f});
            end
        end
    end

    task automatic poke(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(posedge clk);
        #0.5 ld_en = 1'b0;
    endtask

    // releases reset, checks first fetch, returns edges until halted
    task automatic run_prog(output int cyc);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cyc = 1;
        check(mem_rd && mem_addr == 12'd0, "R1", "first fetch read at word 0",
              {19'd0, mem_rd, mem_addr}, {19'd0, 1'b1, 12'd0});
        while (!halted && cyc < 2000) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int cyc;
        // ---------- program 1: arithmetic, flags, branches ----------
        poke(8'h00, 16'h1080); poke(8'h01, 16'h3081); poke(8'h02, 16'h2090);
        poke(8'h03, 16'h4082); poke(8'h04, 16'h6006); poke(8'h05, 16'h2091);
        poke(8'h06, 16'h1083); poke(8'h07, 16'h3084); poke(8'h08, 16'h2092);
        poke(8'h09, 16'h700B); poke(8'h0A, 16'h2093); poke(8'h0B, 16'h4084);
        poke(8'h0C, 16'h600E); poke(8'h0D, 16'h2094); poke(8'h0E, 16'h5010);
        poke(8'h0F, 16'h2095); poke(8'h10, 16'h3085); poke(8'h11, 16'h7013);
        poke(8'h12, 16'h2096); poke(8'h13, 16'hF000);
        poke(8'h80, 16'd5);    poke(8'h81, 16'd7);    poke(8'h82, 16'd12);
        poke(8'h83, 16'h7FFF); poke(8'h84, 16'h0001); poke(8'h85, 16'h8001);
        @(negedge clk);
        check(!halted && !mem_rd && !mem_wr && cond_flags == 4'b0000, "R1",
              "state during reset", {28'd0, halted, mem_rd, mem_wr, |cond_flags}, 32'd0);

        push_wr(12'h090, 16'd12,   4'b0000, "R6");  // 5+7
        push_wr(12'h092, 16'h8000, 4'b1010, "R6");  // 7FFF+1: N,V
        push_wr(12'h094, 16'h7FFF, 4'b0011, "R7");  // 8000-1: V, no borrow
        push_wr(12'h096, 16'h0000, 4'b0101, "R9");  // 7FFF+8001 wraps: Z,C; BN not taken
        run_prog(cyc);
        check(halted, "R10", "halted reached", {31'd0, halted}, 32'd1);
        check(sb_q.size() == 0, "R9", "all expected stores seen", sb_q.size(), 32'd0);
        check(cond_flags == 4'b0101, "R6", "final flags", {28'd0, cond_flags}, 32'h5);
        begin
            bit quiet = 1'b1;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (!halted || mem_rd || mem_wr || cond_flags != 4'b0101) quiet = 1'b0;
            end
            check(quiet, "R10", "halted holds with no strobes", {31'd0, quiet}, 32'd1);
        end
        check(mem[8'h91] == 16'h0000 && mem[8'h93] == 16'h0000 && mem[8'h95] == 16'h0000,
              "R9", "skipped stores left memory untouched",
              {16'd0, mem[8'h91] | mem[8'h93] | mem[8'h95]}, 32'd0);

        // ---------- program 2: reset again, load flags, undefined opcode ----------
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(!halted && cond_flags == 4'b0000, "R1", "reset clears halt and flags",
              {27'd0, halted, cond_flags}, 32'd0);
        poke(8'h00, 16'h1080); poke(8'h01, 16'h6003); poke(8'h02, 16'hF000);
        poke(8'h03, 16'h2090); poke(8'h04, 16'h1081); poke(8'h05, 16'h7007);
        poke(8'h06, 16'hF000); poke(8'h07, 16'h2091); poke(8'h08, 16'h0091);
        poke(8'h09, 16'hF000);
        poke(8'h80, 16'h0000); poke(8'h81, 16'hFFFE);
        push_wr(12'h090, 16'h0000, 4'b0100, "R8");  // load zero: Z only
        push_wr(12'h091, 16'hFFFE, 4'b1000, "R8");  // load negative: N only
        run_prog(cyc);
        // 8+5+7+8+5+7 plus undefined 5 plus halt 5
        check(cyc == 50, "R4", "cycles to halt", cyc, 32'd50);
        check(sb_q.size() == 0, "R3", "undefined opcode issued no store", sb_q.size(), 32'd0);
        check(cond_flags == 4'b1000, "R3", "flags after undefined opcode", {28'd0, cond_flags}, 32'h8);
        repeat (5) @(negedge clk);
        check(halted && !mem_rd && !mem_wr, "R11", "bus idle after halt",
              {29'd0, halted, mem_rd, mem_wr}, 32'h4);
        check(mem[8'h90] == 16'h0000 && mem[8'h91] == 16'hFFFE, "R5", "stored words in memory",
              {mem[8'h90], mem[8'h91]}, 32'h0000_FFFE);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule